// File: doc/BRIEF.md
# Serial-Input Four-State Moore Sequencer

This block is a small Moore machine that takes one serial bit per state time and moves through four states coded in a two-bit register. The high bit of the register is called A and the low bit B. Ones take the machine around a fixed loop, 00 to 11 to 10 to 01 and back to 11. Zeros hold the machine in 11 and in 10. A zero sends it from 01 back to 00, and a zero in 00 keeps it there. The single output is bit B, so it depends only on the present state and does not follow the input between clock edges.

The state register updates on the falling clock edge by default. The input is then read while the clock is high, which matches master/slave timing. A parameter moves the update to the rising edge instead. The state vector is also brought out so that the encoded state can be observed. A synchronous reset returns the machine to 00. The states are named S0 = 00, S1 = 01, S2 = 10 and S3 = 11.

Top module: `seq_moore_fsm`

## Requirements
- R1: While `rst` is high at an update edge, the state becomes 00 (S0) whatever `xIn` is. The output `zOut` is then 0.
- R2: In state 00, `xIn` = 1 moves the machine to 11 and `xIn` = 0 keeps it in 00.
- R3: In state 11, `xIn` = 0 keeps the machine in 11 and `xIn` = 1 moves it to 10.
- R4: In state 10, `xIn` = 0 keeps the machine in 10 and `xIn` = 1 moves it to 01.
- R5: In state 01, `xIn` = 0 moves the machine to 00 and `xIn` = 1 moves it to 11.
- R6: `zOut` always equals state bit B, which is `stateOut[0]`. `stateOut[1]` is bit A. `zOut` changes only when the state changes.
- R7: With `FALL_EDGE` = 1 (the default), the state changes only on the falling edge of `clk`. With `FALL_EDGE` = 0, it changes only on the rising edge.
- R8: Four ones applied after reset take the state through 11, 10, 01 and then 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, sampled at the update edge |
| xIn | input | 1 | Serial data input |
| zOut | output | 1 | Moore output, equal to state bit B |
| stateOut | output | 2 | Present state {A, B} |

## Verification
The bench builds two copies of the block side by side. One uses the default falling-edge update and the other uses `FALL_EDGE` = 0. Both receive the same input stream, which covers all eight arcs of the transition table. Because the two copies share one clock, the bench can sample between a rising edge and the next falling edge. At that point the rising-edge copy has already moved and the falling-edge copy has not, which shows which edge each copy updates on.

// File: rtl/seq_moore_pkg.sv
package seq_moore_pkg;

  localparam int STATE_W = 2;

  // State encoding {A, B}
  typedef enum logic [STATE_W-1:0] {
    S0 = 2'b00,
    S1 = 2'b01,
    S2 = 2'b10,
    S3 = 2'b11
  } seqState_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic      clear;
    logic      load;
    seqState_t nextState;
  } ctrlStrobes_t;

endpackage

// File: rtl/seq_moore_ctrl.sv
module seq_moore_ctrl
  import seq_moore_pkg::*;
(
  input  logic         rst,
  input  logic         xIn,
  input  seqState_t    curState,
  output ctrlStrobes_t strobes
);

  seqState_t target;

  always_comb begin
    unique case (curState)
      S0: target = xIn ? S3 : S0;
      S3: target = xIn ? S2 : S3;
      S2: target = xIn ? S1 : S2;
      S1: target = xIn ? S3 : S0;
      default: target = S0;
    endcase
  end

  always_comb begin
    strobes.clear     = rst;
    strobes.load      = (target != curState);
    strobes.nextState = target;
  end

endmodule

// File: rtl/seq_moore_dp.sv
module seq_moore_dp
  import seq_moore_pkg::*;
#(
  parameter bit FALL_EDGE = 1'b1
) (
  input  logic         clk,
  input  ctrlStrobes_t strobes,
  output seqState_t    curState
);

  seqState_t stateQ;
  seqState_t stateD;

  always_comb begin
    if (strobes.clear)     stateD = S0;
    else if (strobes.load) stateD = strobes.nextState;
    else                   stateD = stateQ;
  end

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk) stateQ <= stateD;
    end else begin : g_rise
      always_ff @(posedge clk) stateQ <= stateD;
    end
  endgenerate

  assign curState = stateQ;

endmodule

// File: rtl/seq_moore_fsm.sv
module seq_moore_fsm
  import seq_moore_pkg::*;
#(
  parameter bit FALL_EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         xIn,
  output logic         zOut,
  output logic [1:0]   stateOut
);

  seqState_t    curState;
  ctrlStrobes_t strobes;

  seq_moore_ctrl uCtrl (
    .rst      (rst),
    .xIn      (xIn),
    .curState (curState),
    .strobes  (strobes)
  );

  seq_moore_dp #(.FALL_EDGE(FALL_EDGE)) uDp (
    .clk      (clk),
    .strobes  (strobes),
    .curState (curState)
  );

  assign stateOut = curState;
  assign zOut     = curState[0];

endmodule

// File: rtl/seq_moore_fsm_chk.sv
module seq_moore_fsm_chk #(
  parameter bit FALL_EDGE = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       xIn,
  input logic       zOut,
  input logic [1:0] stateOut
);

  logic sampClk;
  assign sampClk = FALL_EDGE ? ~clk : clk;

  p_reset_state_r1: assert property (@(posedge sampClk)
    rst |=> (stateOut == 2'b00 && zOut == 1'b0));

  p_s0_arcs_r2: assert property (@(posedge sampClk) disable iff (rst)
    (!rst && stateOut == 2'b00) |=> (stateOut == ($past(xIn) ? 2'b11 : 2'b00)));

  p_s3_arcs_r3: assert property (@(posedge sampClk) disable iff (rst)
    (!rst && stateOut == 2'b11) |=> (stateOut == ($past(xIn) ? 2'b10 : 2'b11)));

  p_s2_arcs_r4: assert property (@(posedge sampClk) disable iff (rst)
    (!rst && stateOut == 2'b10) |=> (stateOut == ($past(xIn) ? 2'b01 : 2'b10)));

  p_s1_arcs_r5: assert property (@(posedge sampClk) disable iff (rst)
    (!rst && stateOut == 2'b01) |=> (stateOut == ($past(xIn) ? 2'b11 : 2'b00)));

  p_z_tracks_b_r6: assert property (@(posedge sampClk)
    $stable(stateOut) |-> $stable(zOut));

endmodule

bind seq_moore_fsm seq_moore_fsm_chk #(.FALL_EDGE(FALL_EDGE)) uChk (
  .clk      (clk),
  .rst      (rst),
  .xIn      (xIn),
  .zOut     (zOut),
  .stateOut (stateOut)
);

// File: tb/tb_seq_moore_fsm.sv
`timescale 1ns/1ps
module tb_seq_moore_fsm;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xIn = 1'b0;
  logic zF, zR;
  logic [1:0] stF, stR;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;   // 125 MHz

  seq_moore_fsm #(.FALL_EDGE(1'b1)) dut (
    .clk(clk), .rst(rst), .xIn(xIn), .zOut(zF), .stateOut(stF));

  seq_moore_fsm #(.FALL_EDGE(1'b0)) dutRise (
    .clk(clk), .rst(rst), .xIn(xIn), .zOut(zR), .stateOut(stR));

  // {x, expected state} from reset; covers all eight arcs
  localparam int NVEC = 11;
  localparam logic [2:0] VECS [NVEC] = '{
    3'b0_00, 3'b1_11, 3'b0_11, 3'b1_10, 3'b0_10, 3'b1_01,
    3'b0_00, 3'b1_11, 3'b1_10, 3'b1_01, 3'b1_11
  };

  task automatic check(input string req, input logic [1:0] act,
                       input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive x after a falling edge; both copies have updated by the next one.
  task automatic step(input logic x);
    xIn = x;
    @(negedge clk); #1;
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(1'b1);
    step(1'b0);
    rst = 1'b0;
  endtask

  initial begin
    #150000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    doReset();
    check("R1 state", stF, 2'b00);
    check("R1 rise state", stR, 2'b00);
    check("R1 z", {1'b0, zF}, 2'b00);

    // Vector walk: R2 R3 R4 R5 arcs, R6 output
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i][2]);
      check("R2-5 arc fall", stF, VECS[i][1:0]);
      check("R2-5 arc rise", stR, VECS[i][1:0]);
      check("R6 z is B", {1'b0, zF}, {1'b0, VECS[i][0]});
      check("R6 rise z", {1'b0, zR}, {1'b0, VECS[i][0]});
    end

    // R8: four ones from reset
    doReset();
    step(1'b1); check("R8 first", stF, 2'b11);
    step(1'b1); check("R8 second", stF, 2'b10);
    step(1'b1); check("R8 third", stF, 2'b01);
    step(1'b1); check("R8 fourth", stF, 2'b11);

    // R1: reset overrides x=1 from state 10
    step(1'b1); check("R1 pre", stF, 2'b10);
    rst = 1'b1;
    step(1'b1);
    check("R1 override fall", stF, 2'b00);
    check("R1 override rise", stR, 2'b00);
    rst = 1'b0;

    // R7: between rising and falling edge only the rising copy has moved
    xIn = 1'b1;
    @(posedge clk); #1;
    check("R7 fall not yet", stF, 2'b00);
    check("R7 rise moved", stR, 2'b11);
    check("R6 z held", {1'b0, zF}, 2'b00);
    @(negedge clk); #1;
    check("R7 fall moved", stF, 2'b11);
    check("R7 rise held", stR, 2'b11);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule